// File: doc/BRIEF.md
# Write Protection and Status Unit

This unit guards the program path of a small serial nonvolatile byte store. It holds the write enable latch and two block-protect bits, and it times the internal programming cycle. The command decoder tells it about enable-set and enable-clear commands and about data writes and status writes that have been received. It also passes in the chip-select level and the write-protect pin. When chip select is released, the unit decides whether the pending write may start. If it may, the unit runs a busy period of a fixed number of clocks.

The unit always presents an 8-bit status byte for status reads. A data write that is accepted raises a one-clock launch strobe, which the array side uses to commit its page buffer. A status write changes only the two protect bits, and the new value takes effect when its busy period ends. Register reset stands for power-up. The protect bits live in flip-flops.

Top module: `wprot_status`

## Requirements
- R1: After reset the status byte reads 0x00 and no write cycle is running.
- R2: When idle, the status byte is bit0 = 0 (ready), bit1 = enable latch, bit2 = low protect bit, bit3 = high protect bit, and bits 7..4 = 0.
- R3: While a write cycle runs, the status byte reads 0xFF.
- R4: An enable-set command sets the latch only when wp_i is high. An enable-clear command clears the latch whatever the level of wp_i.
- R5: The protect bits select the blocked addresses. 00 blocks none, 01 blocks the top quarter (two address MSBs = 11), 10 blocks the top half (address MSB = 1), and 11 blocks every address. With the default 9-bit address these ranges are 0x180–0x1FF, 0x100–0x1FF and all.
- R6: A pending data write launches when chip select rises, with data_go_o high in the cycle in which sel_n_i is first seen high. It launches only if wp_i is high, the latch is set and the address is not blocked. Otherwise it is dropped, and no cycle starts.
- R7: If wp_i goes low at any time while the request is pending, the request is cancelled, even if wp_i returns high before chip select rises. The latch is left unchanged.
- R8: An accepted write keeps the unit busy for exactly WR_CYCLES clocks. A change of wp_i during the cycle has no effect on it.
- R9: The enable latch is cleared when a write cycle ends.
- R10: A status write is checked like a data write, except that no address check applies. It runs the same busy period and then loads bp_i into the protect bits.
- R11: While busy, enable commands and write requests are ignored. A chip-select release after the cycle then starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| sel_n_i | input | 1 | Chip-select level, active low; its rising edge commits a pending write |
| wp_i | input | 1 | Write-protect pin level; high allows writes |
| set_en_i | input | 1 | One-clock strobe: enable-set command decoded |
| clr_en_i | input | 1 | One-clock strobe: enable-clear command decoded |
| arm_data_i | input | 1 | One-clock strobe: data write received, address on addr_i |
| arm_stat_i | input | 1 | One-clock strobe: status write received, new bits on bp_i |
| addr_i | input | ADDR_W | Target byte address of a data write |
| bp_i | input | 2 | New protect bits of a status write |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Write cycle in progress |
| data_go_o | output | 1 | Launch strobe for an accepted data write |

## Verification
The bench steps through all four protection levels. At each level it tries a data write to every address of the 512-byte space. This shows whether the quarter, half and full decodes sit on the right address boundaries and whether an accepted write always leaves the latch cleared. Separate sequences cover each gating condition on its own. One issues a set with the pin low, one writes without enable, one drops the pin briefly while selected, and one drops it only at release. This shows which of the three conditions the launch decision actually checks. Further cases send commands and a status write during a running cycle and toggle the pin mid-cycle. These show that a cycle can be neither disturbed nor extended and that queued requests do not launch afterwards.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [1:0] {
    BP_NONE    = 2'b00,
    BP_QUARTER = 2'b01,
    BP_HALF    = 2'b10,
    BP_ALL     = 2'b11
  } bp_lvl_e;

  typedef enum logic {
    REQ_DATA = 1'b0,
    REQ_STAT = 1'b1
  } req_kind_e;

  localparam logic [7:0] STATUS_BUSY = 8'hFF;
endpackage

// File: rtl/wps_rst_sync.sv
module wps_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/wps_prot_decode.sv
module wps_prot_decode #(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bp,
  output logic              blocked
);
  import wps_pkg::*;

  always_comb begin
    unique case (bp_lvl_e'(bp))
      BP_NONE:    blocked = 1'b0;
      BP_QUARTER: blocked = &addr[ADDR_W-1 -: 2];
      BP_HALF:    blocked = addr[ADDR_W-1];
      default:    blocked = 1'b1;
    endcase
  end
endmodule

// File: rtl/wps_cycle_timer.sv
module wps_cycle_timer #(
  parameter int CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  assign last = busy_q && (cnt_q == LAST_CNT);
  assign busy = busy_q;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/wprot_status.sv
module wprot_status #(
  parameter int ADDR_W    = 9,
  parameter int WR_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              wp_i,
  input  logic              set_en_i,
  input  logic              clr_en_i,
  input  logic              arm_data_i,
  input  logic              arm_stat_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        bp_i,
  output logic [7:0]        status_o,
  output logic              busy_o,
  output logic              data_go_o
);
  import wps_pkg::*;

  logic              rst_i_n;
  logic              sel_q;
  logic              wel_q, wel_d;
  logic [1:0]        bp_q, bp_d;
  logic              pend_q, pend_d;
  req_kind_e         kind_q, kind_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic [1:0]        pbp_q, pbp_d;
  logic              busy, last, blocked, sel_rise, launch;

  wps_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  wps_prot_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (paddr_q),
    .bp      (bp_q),
    .blocked (blocked)
  );

  wps_cycle_timer #(.CYCLES(WR_CYCLES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_i_n),
    .start (launch),
    .busy  (busy),
    .last  (last)
  );

  assign sel_rise = !sel_q && sel_n_i;
  assign launch   = sel_rise && pend_q && wp_i && wel_q && !busy &&
                    ((kind_q == REQ_STAT) || !blocked);

  // Request capture: ignored while busy; pin low or release clears it.
  always_comb begin
    pend_d  = pend_q;
    kind_d  = kind_q;
    paddr_d = paddr_q;
    pbp_d   = pbp_q;
    if (!busy && (arm_data_i || arm_stat_i)) begin
      pend_d = 1'b1;
      kind_d = arm_stat_i ? REQ_STAT : REQ_DATA;
      if (arm_data_i) paddr_d = addr_i;
      if (arm_stat_i) pbp_d   = bp_i;
    end
    if (!wp_i || sel_rise) pend_d = 1'b0;
  end

  // Enable latch and protect bits.
  always_comb begin
    wel_d = wel_q;
    bp_d  = bp_q;
    if (last) begin
      wel_d = 1'b0;
      if (kind_q == REQ_STAT) bp_d = pbp_q;
    end else if (!busy) begin
      if (clr_en_i)           wel_d = 1'b0;
      else if (set_en_i && wp_i) wel_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      sel_q   <= 1'b1;
      wel_q   <= 1'b0;
      bp_q    <= 2'b00;
      pend_q  <= 1'b0;
      kind_q  <= REQ_DATA;
      paddr_q <= '0;
      pbp_q   <= 2'b00;
    end else begin
      sel_q   <= sel_n_i;
      wel_q   <= wel_d;
      bp_q    <= bp_d;
      pend_q  <= pend_d;
      kind_q  <= kind_d;
      paddr_q <= paddr_d;
      pbp_q   <= pbp_d;
    end
  end

  assign status_o  = busy ? STATUS_BUSY : {4'b0000, bp_q, wel_q, 1'b0};
  assign busy_o    = busy;
  assign data_go_o = launch && (kind_q == REQ_DATA);
endmodule

// File: rtl/wprot_status_chk.sv
module wprot_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_i,
  input logic [7:0] status_o,
  input logic       busy_o,
  input logic       data_go_o
);
  a_r3_busy_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> status_o == 8'hFF);

  a_r2_idle_layout: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (status_o[7:4] == 4'h0) && !status_o[0]);

  a_r6_go_gated: assert property (@(posedge clk) disable iff (!rst_n)
    data_go_o |-> wp_i && status_o[1] && !busy_o);

  a_r8_go_starts_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    data_go_o |=> busy_o);

  a_r9_end_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !status_o[1]);

  a_r4_set_needs_wp: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o) && $rose(status_o[1])) |-> $past(wp_i));

  a_r10_bp_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(status_o[3:2]));
endmodule

bind wprot_status wprot_status_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wp_i      (wp_i),
  .status_o  (status_o),
  .busy_o    (busy_o),
  .data_go_o (data_go_o)
);

// File: tb/wprot_status_bench.sv
`timescale 1ns/1ps
module wprot_status_bench;
  localparam int AW = 9;
  localparam int N  = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_n, wp, set_en, clr_en, arm_d, arm_s;
  logic [AW-1:0] addr;
  logic [1:0]    bp;
  logic [7:0]    status_o;
  logic          busy_o, data_go_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  wprot_status #(.ADDR_W(AW), .WR_CYCLES(N)) u_wprot_status (
    .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .wp_i(wp),
    .set_en_i(set_en), .clr_en_i(clr_en), .arm_data_i(arm_d),
    .arm_stat_i(arm_s), .addr_i(addr), .bp_i(bp),
    .status_o(status_o), .busy_o(busy_o), .data_go_o(data_go_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic strobe_set();
    @(negedge clk) set_en = 1'b1;
    @(negedge clk) set_en = 1'b0;
  endtask

  task automatic strobe_clr();
    @(negedge clk) clr_en = 1'b1;
    @(negedge clk) clr_en = 1'b0;
  endtask

  // Select, arm one request, release; returns launch strobe seen at release.
  task automatic txn(input bit stat, input int a, input int b, output bit go);
    @(negedge clk);
    sel_n = 1'b0; arm_d = !stat; arm_s = stat;
    addr = AW'(a); bp = 2'(b);
    @(negedge clk);
    arm_d = 1'b0; arm_s = 1'b0;
    @(negedge clk);
    sel_n = 1'b1;
    #0.5 go = data_go_o;
    @(negedge clk);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy_o && n < 10 * N) begin
      n++;
      @(negedge clk);
    end
  endtask

  function automatic bit blocked(input int a, input int b);
    case (b)
      0: return 1'b0;
      1: return a >= 384;
      2: return a >= 256;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit go;
    int n;
    rst_n = 1'b0; sel_n = 1'b1; wp = 1'b1; set_en = 1'b0; clr_en = 1'b0;
    arm_d = 1'b0; arm_s = 1'b0; addr = '0; bp = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 reset status", status_o, 8'h00);
    chk("R1 reset busy", busy_o, 0);

    // R4: set needs pin high, clear does not
    wp = 1'b0; strobe_set();
    chk("R4 set ignored with wp low", status_o, 8'h00);
    wp = 1'b1; strobe_set();
    chk("R4 R2 set with wp high", status_o, 8'h02);
    wp = 1'b0; strobe_clr();
    chk("R4 clear with wp low", status_o, 8'h00);
    wp = 1'b1;

    // R6: write without enable dropped
    txn(1'b0, 5, 0, go);
    chk("R6 no enable go", go, 0);
    chk("R6 no enable busy", busy_o, 0);

    // R7: pin pulse while selected cancels even after it returns high
    strobe_set();
    @(negedge clk); sel_n = 1'b0; arm_d = 1'b1; addr = 9'd7;
    @(negedge clk); arm_d = 1'b0; wp = 1'b0;
    @(negedge clk); wp = 1'b1;
    @(negedge clk); sel_n = 1'b1;
    #0.5 chk("R7 cancelled go", data_go_o, 0);
    @(negedge clk);
    chk("R7 no cycle, latch kept", status_o, 8'h02);

    // R6: pin low at release drops the write
    @(negedge clk); sel_n = 1'b0; arm_d = 1'b1; addr = 9'd9;
    @(negedge clk); arm_d = 1'b0;
    @(negedge clk); wp = 1'b0; sel_n = 1'b1;
    #0.5 chk("R6 wp low at release go", data_go_o, 0);
    @(negedge clk); wp = 1'b1;
    chk("R6 wp low at release busy", busy_o, 0);

    // R8: pin change mid-cycle has no effect; R3 and R9
    txn(1'b0, 3, 0, go);
    chk("R6 accepted go", go, 1);
    chk("R3 busy status", status_o, 8'hFF);
    wp = 1'b0;
    wait_idle(n);
    wp = 1'b1;
    chk("R8 duration with wp toggled", n, N);
    chk("R9 latch cleared", status_o, 8'h00);

    // R5 R6 R10: sweep levels and addresses
    for (int lvl = 0; lvl < 4; lvl++) begin
      strobe_set();
      txn(1'b1, 0, lvl, go);
      chk("R10 status write no data go", go, 0);
      wait_idle(n);
      chk("R10 status cycle length", n, N);
      chk("R10 R2 protect bits", status_o, lvl << 2);
      for (int a = 0; a < (1 << AW); a++) begin
        bit exp_go;
        exp_go = !blocked(a, lvl);
        strobe_set();
        txn(1'b0, a, 0, go);
        chk("R5 R6 launch decision", go, exp_go);
        wait_idle(n);
        if (exp_go) chk("R8 cycle length", n, N);
        chk("R9 R5 status after", status_o, (lvl << 2) | (exp_go ? 0 : 2));
        if (!exp_go) strobe_clr();
      end
    end

    // R10: status write allowed at full protection
    strobe_set();
    txn(1'b1, 0, 1, go);
    wait_idle(n);
    chk("R10 rewrite bp at full protect", status_o, 8'h04);

    // R11: commands and requests during busy ignored
    strobe_set();
    txn(1'b0, 0, 0, go);
    chk("R11 setup go", go, 1);
    @(negedge clk); sel_n = 1'b0; arm_s = 1'b1; bp = 2'b11; set_en = 1'b1;
    @(negedge clk); arm_s = 1'b0; set_en = 1'b0;
    chk("R3 busy during request", status_o, 8'hFF);
    wait_idle(n);
    @(negedge clk); sel_n = 1'b1;
    @(negedge clk);
    chk("R11 no cycle after release", busy_o, 0);
    chk("R11 bits unchanged", status_o, 8'h04);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule